// File: doc/BRIEF.md
# Extended 64-bit Integer ALU

A purely combinational integer arithmetic/logic unit for a 64-bit datapath. It takes two 64-bit source operands and a 7-bit operation code and returns one 64-bit result in the same cycle. The three high bits of the code pick an operation family. The four low bits pick the operation within that family.

Besides the usual shifts, rotates, single-bit manipulation, word (32-bit) arithmetic, compare and logic operations, the unit covers several fused operations. These are meant for pairs of instructions that a front end has merged. They include adding only bit 0 of the first operand, adding a logically right-shifted first operand, folding a 12-bit low immediate and an upper immediate held in one source, adds whose sum is cut to one bit, a byte or a halfword, and logic operations whose result is cut to its lowest bit or to its low halfword. Any code that is not defined returns zero.

Top module: `xint_alu`

## Requirements
- R1: Family 000 (top code bits 6:4). Low code 0000 is logical left shift of the zero-extended src_a[31:0]. 0001 is logical left shift, 0101 is logical right shift and 0111 is arithmetic right shift of src_a. 1001 is rotate left and 1011 is rotate right. All of these use src_b[5:0] as the amount, and a rotate by 0 returns src_a.
- R2: Family 000 single-bit operations use bit index src_b[5:0]. Low code 0010 clears that bit of src_a, 0011 sets it, 0100 inverts it (src_a XOR one-hot), and 0110 returns that bit in result bit 0 with all other bits zero.
- R3: Family 001 word operations sign-extend bit 31 of a 32-bit value. Low code 0000 is a+b, 0001 is src_a[0]+src_b, and 0010 is a-b. 1000, 1001 and 1010 shift src_a[31:0] left, logically right and arithmetically right. 1100 and 1101 rotate src_a[31:0] left and right. All word shifts and rotates use src_b[4:0].
- R4: Code 0010011 gives sext64(sext32(src_b[11:0]) + {src_b[31:12],12'b0}) computed in 32 bits. Code 0100011 gives sext64(src_b[11:0]) + {src_b[63:12],12'b0}.
- R5: With s = src_a+src_b, code 0010100 gives s[0] zero-extended and 0010101 gives s[7:0] zero-extended. 0010110 gives s[15:0] zero-extended and 0010111 gives s[15:0] sign-extended.
- R6: Code 0100000 gives zext(src_a[31:0])+src_b, 0100001 gives src_a+src_b, and 0100010 gives src_a[0]+src_b. Codes 0100100, 0100101, 0100110 and 0100111 give (src_a>>k)+src_b for k = 29, 30, 31 and 32 (logical shift).
- R7: Codes 0101001, 0101011, 0101101 and 0101111 give (src_a<<n)+src_b for n = 1, 2, 3 and 4. Codes 0101000, 0101010 and 0101100 do the same for n = 1, 2 and 3 on the zero-extended src_a[31:0].
- R8: Family 011. Low code 0000 is a-b. 0001 gives the unsigned a<b flag in bit 0 and 0010 gives the signed a<b flag in bit 0. 0100 is unsigned max, 0101 unsigned min, 0110 signed max and 0111 signed min.
- R9: Family 100. Low code 0000 is and, 0001 is a&~b, 0010 is or, 0011 is a|~b, 0100 is xor and 0101 is xnor. 0110 sets each byte of the result to 8'hFF when the matching byte of src_a is nonzero, and to zero otherwise.
- R10: Codes 1100fgz apply the family-100 operation with low code {0,f,g,0} (and, or, xor, byte-or-combine). When z=0 the result is cut to bit 0. When z=1 it is cut to the low 16 bits, zero-extended.
- R11: Every other code returns zero. This covers families 101 and 111, 1101xxx, 0111xxx, 1001xxx, 0001000, 0001010, 00011xx, 0011011, 001111x, 0101110, 0110011 and 1000111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand (also shift amount, bit index, immediates) |
| opcode | input | 7 | Operation code, family in bits 6:4 |
| result | output | 64 | Operation result |

## Verification
The hardest cases to reach are the boundary ones. These are shift amounts that cross the 32-bit word edge, and rotates by zero, where a careless rotate shifts by the full width. Sign handling in slt, min and max with the most-negative value is also hard to reach, as are the zero results of undefined codes packed in next to defined ones. The stimulus sweeps all 128 codes against every pair drawn from an operand list. That list holds zero, all ones, the most-negative value, the amounts 0, 31, 32 and 63, immediate-shaped values with bit 11 set, and seeded random words. Each result is compared with an arithmetic reference written out separately for each code.

// File: rtl/xint_alu_pkg.sv
package xint_alu_pkg;
   localparam int          OPW        = 7;
   localparam logic [2:0]  FAM_SHIFT  = 3'b000;
   localparam logic [2:0]  FAM_WORD   = 3'b001;
   localparam logic [2:0]  FAM_ADD    = 3'b010;
   localparam logic [2:0]  FAM_CMP    = 3'b011;
   localparam logic [2:0]  FAM_LOGIC  = 3'b100;
   localparam logic [2:0]  FAM_NARROW = 3'b110;
   localparam int          NARROW_W   = 16;
   localparam int          HS_BASE    = 29;
   localparam int          HS_COUNT   = 4;
   localparam int          SHADD_MAX  = 4;
   localparam int          IMM_LO     = 12;
endpackage

// File: rtl/xint_alu_shift.sv
module xint_alu_shift #(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN),
   localparam int HALF = XLEN / 2
) (
   input  logic [XLEN-1:0] a,
   input  logic [SHW-1:0]  amt,
   input  logic [3:0]      sel,
   output logic [XLEN-1:0] res
);
   logic [XLEN-1:0]   onehot, a_zx;
   logic [2*XLEN-1:0] dbl_l, dbl_r;

   assign onehot = {{(XLEN-1){1'b0}}, 1'b1} << amt;
   assign a_zx   = {{HALF{1'b0}}, a[HALF-1:0]};
   assign dbl_l  = {a, a} << amt;
   assign dbl_r  = {a, a} >> amt;

   always_comb begin
      case (sel)
         4'b0000: res = a_zx << amt;
         4'b0001: res = a << amt;
         4'b0010: res = a & ~onehot;
         4'b0011: res = a | onehot;
         4'b0100: res = a ^ onehot;
         4'b0101: res = a >> amt;
         4'b0110: res = {{(XLEN-1){1'b0}}, |(a & onehot)};
         4'b0111: res = $signed(a) >>> amt;
         4'b1001: res = dbl_l[2*XLEN-1:XLEN];
         4'b1011: res = dbl_r[XLEN-1:0];
         default: res = '0;
      endcase
   end

   always_comb begin
      if (sel == 4'b0110)
         assert_bext_one_bit_R2: assert (res[XLEN-1:1] == '0)
            else $error("bit extract wider than one bit");
      if ((sel == 4'b1001 || sel == 4'b1011) && amt == '0)
         assert_rotate_zero_R1: assert (res == a)
            else $error("rotate by zero changed operand");
   end
endmodule

// File: rtl/xint_alu_arith.sv
module xint_alu_arith
   import xint_alu_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int HALF = XLEN / 2,
   localparam int WSHW = $clog2(HALF)
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            is_word,
   input  logic [3:0]      sel,
   output logic [XLEN-1:0] res
);
   function automatic logic [XLEN-1:0] sx_w(input logic [HALF-1:0] v);
      return {{HALF{v[HALF-1]}}, v};
   endfunction

   logic [XLEN-1:0]   sum, diff, odd_sum, a_zx, lui_d;
   logic [HALF-1:0]   a_w, lui_w, sll_w, srl_w, sra_w;
   logic [WSHW-1:0]   sh5;
   logic [XLEN-1:0]   dbl_wl, dbl_wr;
   logic [XLEN-1:0]   word_res, add_res;
   logic [XLEN-1:0]   hadd   [HS_COUNT];
   logic [XLEN-1:0]   sh_all [1:SHADD_MAX];
   logic [XLEN-1:0]   sh_uw  [1:SHADD_MAX-1];

   assign a_w     = a[HALF-1:0];
   assign a_zx    = {{HALF{1'b0}}, a_w};
   assign sh5     = b[WSHW-1:0];
   assign sum     = a + b;
   assign diff    = a - b;
   assign odd_sum = {{(XLEN-1){1'b0}}, a[0]} + b;
   assign lui_w   = {{(HALF-IMM_LO){b[IMM_LO-1]}}, b[IMM_LO-1:0]} + {b[HALF-1:IMM_LO], {IMM_LO{1'b0}}};
   assign lui_d   = {{(XLEN-IMM_LO){b[IMM_LO-1]}}, b[IMM_LO-1:0]} + {b[XLEN-1:IMM_LO], {IMM_LO{1'b0}}};
   assign sll_w   = a_w << sh5;
   assign srl_w   = a_w >> sh5;
   assign sra_w   = $signed(a_w) >>> sh5;
   assign dbl_wl  = {a_w, a_w} << sh5;
   assign dbl_wr  = {a_w, a_w} >> sh5;

   for (genvar k = 0; k < HS_COUNT; k++) begin : g_hadd
      assign hadd[k] = (a >> (HS_BASE + k)) + b;
   end
   for (genvar n = 1; n <= SHADD_MAX; n++) begin : g_shadd
      assign sh_all[n] = (a << n) + b;
      if (n < SHADD_MAX) begin : g_uw
         assign sh_uw[n] = (a_zx << n) + b;
      end
   end

   always_comb begin
      case (sel)
         4'b0000: word_res = sx_w(sum[HALF-1:0]);
         4'b0001: word_res = sx_w(odd_sum[HALF-1:0]);
         4'b0010: word_res = sx_w(diff[HALF-1:0]);
         4'b0011: word_res = sx_w(lui_w);
         4'b0100: word_res = {{(XLEN-1){1'b0}}, sum[0]};
         4'b0101: word_res = {{(XLEN-8){1'b0}}, sum[7:0]};
         4'b0110: word_res = {{(XLEN-NARROW_W){1'b0}}, sum[NARROW_W-1:0]};
         4'b0111: word_res = {{(XLEN-NARROW_W){sum[NARROW_W-1]}}, sum[NARROW_W-1:0]};
         4'b1000: word_res = sx_w(sll_w);
         4'b1001: word_res = sx_w(srl_w);
         4'b1010: word_res = sx_w(sra_w);
         4'b1100: word_res = sx_w(dbl_wl[XLEN-1:HALF]);
         4'b1101: word_res = sx_w(dbl_wr[HALF-1:0]);
         default: word_res = '0;
      endcase
   end

   always_comb begin
      case (sel)
         4'b0000: add_res = a_zx + b;
         4'b0001: add_res = sum;
         4'b0010: add_res = odd_sum;
         4'b0011: add_res = lui_d;
         4'b0100, 4'b0101, 4'b0110, 4'b0111: add_res = hadd[sel[1:0]];
         4'b1000: add_res = sh_uw[1];
         4'b1001: add_res = sh_all[1];
         4'b1010: add_res = sh_uw[2];
         4'b1011: add_res = sh_all[2];
         4'b1100: add_res = sh_uw[3];
         4'b1101: add_res = sh_all[3];
         4'b1111: add_res = sh_all[4];
         default: add_res = '0;
      endcase
   end

   assign res = is_word ? word_res : add_res;

   always_comb begin
      if (is_word && sel[3:2] != 2'b01)
         assert_word_sign_ext_R3: assert (&res[XLEN-1:HALF-1] || ~|res[XLEN-1:HALF-1])
            else $error("word result not sign extended");
      if (is_word && sel == 4'b0100)
         assert_trunc_bit_R5: assert (res[XLEN-1:1] == '0)
            else $error("truncated bit result too wide");
      if (is_word && sel == 4'b0110)
         assert_trunc_half_R5: assert (res[XLEN-1:NARROW_W] == '0)
            else $error("truncated halfword not zero extended");
   end
endmodule

// File: rtl/xint_alu_cmp.sv
module xint_alu_cmp #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [3:0]      sel,
   output logic [XLEN-1:0] res
);
   logic lt_u, lt_s;

   assign lt_u = a < b;
   assign lt_s = $signed(a) < $signed(b);

   always_comb begin
      case (sel)
         4'b0000: res = a - b;
         4'b0001: res = {{(XLEN-1){1'b0}}, lt_u};
         4'b0010: res = {{(XLEN-1){1'b0}}, lt_s};
         4'b0100: res = lt_u ? b : a;
         4'b0101: res = lt_u ? a : b;
         4'b0110: res = lt_s ? b : a;
         4'b0111: res = lt_s ? a : b;
         default: res = '0;
      endcase
   end

   always_comb begin
      if (sel == 4'b0001 || sel == 4'b0010)
         assert_flag_one_bit_R8: assert (res[XLEN-1:1] == '0)
            else $error("compare flag wider than one bit");
      if (sel[3:2] == 2'b01)
         assert_minmax_picks_source_R8: assert (res == a || res == b)
            else $error("min/max result is neither source");
   end
endmodule

// File: rtl/xint_alu_logic.sv
module xint_alu_logic
   import xint_alu_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int NBYTE = XLEN / 8
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            narrow,
   input  logic [3:0]      sel,
   output logic [XLEN-1:0] res
);
   logic [XLEN-1:0] orc;
   logic [XLEN-1:0] wide_v, base_v;

   for (genvar i = 0; i < NBYTE; i++) begin : g_orc
      assign orc[8*i +: 8] = {8{|a[8*i +: 8]}};
   end

   function automatic logic [XLEN-1:0] pick(input logic [2:0] f, input logic [XLEN-1:0] x,
                                            input logic [XLEN-1:0] y, input logic [XLEN-1:0] oc);
      case (f)
         3'b000:  return x & y;
         3'b001:  return x & ~y;
         3'b010:  return x | y;
         3'b011:  return x | ~y;
         3'b100:  return x ^ y;
         3'b101:  return ~(x ^ y);
         3'b110:  return oc;
         default: return '0;
      endcase
   endfunction

   assign wide_v = pick(sel[2:0], a, b, orc);
   assign base_v = pick({sel[2:1], 1'b0}, a, b, orc);

   always_comb begin
      if (sel[3])
         res = '0;
      else if (!narrow)
         res = wide_v;
      else if (sel[0])
         res = {{(XLEN-NARROW_W){1'b0}}, base_v[NARROW_W-1:0]};
      else
         res = {{(XLEN-1){1'b0}}, base_v[0]};
   end

   always_comb begin
      if (narrow && !sel[0])
         assert_lsb_reduce_R10: assert (res[XLEN-1:1] == '0)
            else $error("lsb-reduced logic too wide");
      if (narrow && sel[0])
         assert_half_zext_R10: assert (res[XLEN-1:NARROW_W] == '0)
            else $error("halfword logic not zero extended");
   end
endmodule

// File: rtl/xint_alu.sv
module xint_alu
   import xint_alu_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   input  logic [OPW-1:0]  opcode,
   output logic [XLEN-1:0] result
);
   if (XLEN != 64) begin : g_bad_xlen
      $error("xint_alu: XLEN must be 64");
   end

   logic [2:0]      fam;
   logic [3:0]      sel;
   logic [XLEN-1:0] shift_res, arith_res, cmp_res, logic_res;

   assign fam = opcode[OPW-1:OPW-3];
   assign sel = opcode[3:0];

   xint_alu_shift #(.XLEN(XLEN)) u_shift (
      .a(src_a), .amt(src_b[SHW-1:0]), .sel(sel), .res(shift_res));

   xint_alu_arith #(.XLEN(XLEN)) u_arith (
      .a(src_a), .b(src_b), .is_word(opcode[4]), .sel(sel), .res(arith_res));

   xint_alu_cmp #(.XLEN(XLEN)) u_cmp (
      .a(src_a), .b(src_b), .sel(sel), .res(cmp_res));

   xint_alu_logic #(.XLEN(XLEN)) u_logic (
      .a(src_a), .b(src_b), .narrow(opcode[5]), .sel(sel), .res(logic_res));

   always_comb begin
      case (fam)
         FAM_SHIFT:            result = shift_res;
         FAM_WORD, FAM_ADD:    result = arith_res;
         FAM_CMP:              result = cmp_res;
         FAM_LOGIC, FAM_NARROW: result = logic_res;
         default:              result = '0;
      endcase
   end

   always_comb begin
      if (fam == 3'b101 || fam == 3'b111)
         assert_unknown_family_zero_R11: assert (result == '0)
            else $error("undefined family produced nonzero result");
   end
endmodule

// File: tb/xint_alu_bench.sv
`timescale 1ns/1ps
module xint_alu_bench;
   logic        clk = 1'b0;
   logic [63:0] src_a, src_b, result;
   logic [6:0]  opcode;
   int          total = 0;
   int          bad = 0;
   int          cycles = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   xint_alu u_xint_alu (.src_a(src_a), .src_b(src_b), .opcode(opcode), .result(result));

   function automatic logic [63:0] sx32(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction
   function automatic logic [63:0] rl64(input logic [63:0] x, input int s);
      return (s == 0) ? x : ((x << s) | (x >> (64 - s)));
   endfunction
   function automatic logic [31:0] rl32(input logic [31:0] x, input int s);
      return (s == 0) ? x : ((x << s) | (x >> (32 - s)));
   endfunction
   function automatic logic [63:0] orcomb(input logic [63:0] x);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[8*i +: 8] = (x[8*i +: 8] != 8'h00) ? 8'hFF : 8'h00;
      return r;
   endfunction

   function automatic bit model(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r);
      int s, w;
      logic [63:0] t, az;
      logic [31:0] lw;
      s  = int'(b[5:0]);
      w  = int'(b[4:0]);
      t  = a + b;
      az = {32'h0, a[31:0]};
      lw = {{20{b[11]}}, b[11:0]} + {b[31:12], 12'h000};
      model = 1'b1;
      case (op)
         7'b0000000: r = az << s;
         7'b0000001: r = a << s;
         7'b0000010: r = a & ~(64'd1 << s);
         7'b0000011: r = a | (64'd1 << s);
         7'b0000100: r = a ^ (64'd1 << s);
         7'b0000101: r = a >> s;
         7'b0000110: r = {63'd0, a[s]};
         7'b0000111: r = $signed(a) >>> s;
         7'b0001001: r = rl64(a, s);
         7'b0001011: r = rl64(a, (64 - s) % 64);
         7'b0010000: r = sx32(t[31:0]);
         7'b0010001: r = sx32(b[31:0] + {31'd0, a[0]});
         7'b0010010: r = sx32(a[31:0] - b[31:0]);
         7'b0010011: r = sx32(lw);
         7'b0010100: r = {63'd0, t[0]};
         7'b0010101: r = {56'd0, t[7:0]};
         7'b0010110: r = {48'd0, t[15:0]};
         7'b0010111: r = {{48{t[15]}}, t[15:0]};
         7'b0011000: r = sx32(a[31:0] << w);
         7'b0011001: r = sx32(a[31:0] >> w);
         7'b0011010: r = sx32($signed(a[31:0]) >>> w);
         7'b0011100: r = sx32(rl32(a[31:0], w));
         7'b0011101: r = sx32(rl32(a[31:0], (32 - w) % 32));
         7'b0100000: r = az + b;
         7'b0100001: r = a + b;
         7'b0100010: r = b + {63'd0, a[0]};
         7'b0100011: r = {{52{b[11]}}, b[11:0]} + {b[63:12], 12'h000};
         7'b0100100: r = (a >> 29) + b;
         7'b0100101: r = (a >> 30) + b;
         7'b0100110: r = (a >> 31) + b;
         7'b0100111: r = (a >> 32) + b;
         7'b0101000: r = (az << 1) + b;
         7'b0101001: r = (a << 1) + b;
         7'b0101010: r = (az << 2) + b;
         7'b0101011: r = (a << 2) + b;
         7'b0101100: r = (az << 3) + b;
         7'b0101101: r = (a << 3) + b;
         7'b0101111: r = (a << 4) + b;
         7'b0110000: r = a - b;
         7'b0110001: r = (a < b) ? 64'd1 : 64'd0;
         7'b0110010: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
         7'b0110100: r = (a > b) ? a : b;
         7'b0110101: r = (a > b) ? b : a;
         7'b0110110: r = ($signed(a) > $signed(b)) ? a : b;
         7'b0110111: r = ($signed(a) > $signed(b)) ? b : a;
         7'b1000000: r = a & b;
         7'b1000001: r = a & ~b;
         7'b1000010: r = a | b;
         7'b1000011: r = a | ~b;
         7'b1000100: r = a ^ b;
         7'b1000101: r = ~(a ^ b);
         7'b1000110: r = orcomb(a);
         7'b1100000: r = {63'd0, a[0] & b[0]};
         7'b1100001: r = {48'd0, a[15:0] & b[15:0]};
         7'b1100010: r = {63'd0, a[0] | b[0]};
         7'b1100011: r = {48'd0, a[15:0] | b[15:0]};
         7'b1100100: r = {63'd0, a[0] ^ b[0]};
         7'b1100101: r = {48'd0, a[15:0] ^ b[15:0]};
         7'b1100110: r = {63'd0, |a[7:0]};
         7'b1100111: r = {48'd0, orcomb(a)[15:0]};
         default: begin r = 64'd0; model = 1'b0; end
      endcase
   endfunction

   function automatic string req_of(input logic [6:0] op, input bit defined);
      if (!defined) return "R11";
      casez (op)
         7'b0010011, 7'b0100011:                         return "R4";
         7'b0000010, 7'b0000011, 7'b0000100, 7'b0000110: return "R2";
         7'b000????:                                      return "R1";
         7'b00101??:                                      return "R5";
         7'b001????:                                      return "R3";
         7'b01000??:                                      return "R6";
         7'b0101???:                                      return "R7";
         7'b011????:                                      return "R8";
         7'b100????:                                      return "R9";
         default:                                         return "R10";
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] exp);
      total++;
      if (result !== exp) begin
         bad++;
         $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, opcode, src_a, src_b, result, exp);
      end
   endtask

   logic [63:0] av [12];
   logic [63:0] bv [12];

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] exp;
      bit          def;
      void'($urandom(32'h5eed_1234));
      av[0] = 64'h0;                   av[1] = '1;
      av[2] = 64'h8000_0000_0000_0000; av[3] = 64'h0000_0000_7FFF_FFFF;
      av[4] = 64'h0123_4567_89AB_CDEF; av[5] = 64'hFFFF_FFFF_8000_0000;
      bv[0] = 64'h0;                   bv[1] = '1;
      bv[2] = 64'h8000_0000_0000_0000; bv[3] = 64'd31;
      bv[4] = 64'd32;                  bv[5] = 64'd63;
      bv[6] = 64'h0000_0000_8000_0FFF; bv[7] = 64'hDEAD_BEEF_1234_5800;
      for (int i = 6; i < 12; i++) av[i] = {$urandom, $urandom};
      for (int i = 8; i < 12; i++) bv[i] = {$urandom, $urandom};

      // all-zero inputs give a zero result (R1)
      @(posedge clk);
      src_a = '0; src_b = '0; opcode = '0;
      @(negedge clk);
      check("R1", 64'd0);

      for (int op = 0; op < 128; op++) begin
         for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
               @(posedge clk);
               opcode = 7'(op); src_a = av[i]; src_b = bv[j];
               @(negedge clk);
               def = model(opcode, src_a, src_b, exp);
               check(req_of(opcode, def), exp);
            end
         end
      end

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule